// File: doc/BRIEF.md
# Interrupt Mask, Polarity and Latch Front-End

This block sits between a bank of peripheral interrupt request lines (up to 64) and a parent interrupt controller that accepts only active-high, level-sensitive inputs. Each raw request is first brought into the clock domain by a two-stage synchronizer. It can then be inverted by a per-line polarity bit, so lines that are active-low or fall on their active edge look active-high. After that it is either passed straight through (level lines) or captured in a sticky latch on its rising edge (edge lines). A per-line mask gates the result, and the gated result is registered onto the output.

Software drives the block through a 16-bit register bus with a write strobe, a read strobe and an 8-bit byte address. There are four banks: mask, reverse polarity, end-of-interrupt and edge select. Within a bank each 16-bit word covers sixteen lines, and consecutive words are four bytes apart. Writing a one to a line's end-of-interrupt bit completes the interrupt and clears that line's latch. A build option removes the end-of-interrupt path, so latched requests then stay set.

Top module: `pirq_frontend`

## Requirements
- R1: After reset every mask bit reads 1, every polarity and edge-select bit reads 0, every latch is clear and every output is 0.
- R2: Line n uses bit (n mod 16) of the word at bank base + 4 × (n div 16). The bank bases are mask 0x00, reverse polarity 0x10, end-of-interrupt 0x20 and edge select 0x30.
- R3: A mask bit of 1 forces that line's output to 0. A mask bit of 0 lets the line's pending state through.
- R4: For a level line (edge-select bit 0), the output follows the polarity-corrected input with no latch. The output changes on the third rising clock edge after the raw input changes.
- R5: A polarity bit of 1 inverts the synchronized input before level pass-through and edge detection, so a low input (level) or a falling input (edge) becomes an active request.
- R6: For an edge line (edge-select bit 1), a rising edge of the corrected input sets a latch. The output then stays 1 after the input returns to idle.
- R7: Writing 1 to a line's end-of-interrupt bit clears its latch, and zero bits in that write leave other latches untouched. The end-of-interrupt bank always reads 0.
- R8: If a new edge is detected in the same cycle as an end-of-interrupt write for that line, the latch stays set.
- R9: With the end-of-interrupt option disabled, writes to the end-of-interrupt bank have no effect and latched requests stay set.
- R10: Mask, polarity and edge-select words read back what was written, after a one-cycle read latency. Bits for lines at or above the line count read 0 and cannot be written. Unmapped or misaligned addresses read 0 and ignore writes.
- R11: Masking an edge line hides its output but keeps its latch, so unmasking shows the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NUM_LINES | Raw asynchronous interrupt requests |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| irq_out | output | NUM_LINES | Active-high level requests to the parent controller |

## Verification
The critical coincidence is an end-of-interrupt write that lands on the same clock edge at which the line's rising edge is detected. The latch could then be cleared by the completion or kept by the new request. The bench first latches an edge line, then raises its raw input again and times the completion write so that it is sampled exactly two synchronizer stages later. It judges the result by seeing the output still high afterwards, and by seeing a second completion with no new edge clear it.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 8;
  localparam int MAX_LINES = 64;

  typedef enum logic [1:0] {
    BANK_MASK = 2'd0,
    BANK_POL  = 2'd1,
    BANK_EOI  = 2'd2,
    BANK_EDGE = 2'd3
  } bank_e;

  typedef struct packed {
    logic       hit;
    bank_e      bank;
    logic [1:0] word;
  } dec_t;

  // Byte address: [7:6] must be zero, [5:4] bank, [3:2] word, [1:0] must be zero.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int n_words);
    dec_t d;
    d.bank = bank_e'(a[5:4]);
    d.word = a[3:2];
    d.hit  = (a[7:6] == 2'b00) && (a[1:0] == 2'b00) && (int'(a[3:2]) < n_words);
    return d;
  endfunction
endpackage

// File: rtl/pirq_sync.sv
`timescale 1ns/1ps
module pirq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign d_out = stage2;
endmodule

// File: rtl/pirq_regs.sv
`timescale 1ns/1ps
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter bit HAS_EOI   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] eoi_o
);
  localparam int NUM_WORDS = (NUM_LINES + REG_W - 1) / REG_W;

  dec_t dec;
  assign dec = decode_addr(bus_addr, NUM_WORDS);

  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] edge_q;
  logic [REG_W-1:0]     rd_word;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    localparam int WIDX = i / REG_W;
    localparam int BIDX = i % REG_W;
    logic sel;
    assign sel = bus_wr && dec.hit && (int'(dec.word) == WIDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i] <= 1'b1;
        pol_q[i]  <= 1'b0;
        edge_q[i] <= 1'b0;
      end else if (sel) begin
        case (dec.bank)
          BANK_MASK: mask_q[i] <= bus_wdata[BIDX];
          BANK_POL:  pol_q[i]  <= bus_wdata[BIDX];
          BANK_EDGE: edge_q[i] <= bus_wdata[BIDX];
          default:   ;
        endcase
      end
    end

    if (HAS_EOI) begin : g_eoi
      assign eoi_o[i] = sel && (dec.bank == BANK_EOI) && bus_wdata[BIDX];
    end else begin : g_no_eoi
      assign eoi_o[i] = 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (dec.hit) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if ((i / REG_W) == int'(dec.word)) begin
          case (dec.bank)
            BANK_MASK: rd_word[i % REG_W] = mask_q[i];
            BANK_POL:  rd_word[i % REG_W] = pol_q[i];
            BANK_EDGE: rd_word[i % REG_W] = edge_q[i];
            default:   rd_word[i % REG_W] = 1'b0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/pirq_detect.sv
`timescale 1ns/1ps
module pirq_detect #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sync_in,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] edge_sel,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] eoi,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] latch_o,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] corr;
  logic [NUM_LINES-1:0] corr_d;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] latch_q;
  logic [NUM_LINES-1:0] pend;

  assign corr = sync_in ^ pol;
  assign rise = corr & ~corr_d & edge_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_d  <= '0;
      latch_q <= '0;
      irq_out <= '0;
    end else begin
      corr_d  <= corr;
      // A new edge wins over a completion in the same cycle.
      latch_q <= (latch_q & ~eoi) | rise;
      irq_out <= pend & ~mask;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
    assign pend[i] = edge_sel[i] ? latch_q[i] : corr[i];
  end

  assign latch_o = latch_q;
  assign rise_o  = rise;
endmodule

// File: rtl/pirq_frontend.sv
`timescale 1ns/1ps
module pirq_frontend
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter bit HAS_EOI   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_raw,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] sync_v;
  logic [NUM_LINES-1:0] mask_v;
  logic [NUM_LINES-1:0] pol_v;
  logic [NUM_LINES-1:0] edge_v;
  logic [NUM_LINES-1:0] eoi_v;
  logic [NUM_LINES-1:0] latch_v;
  logic [NUM_LINES-1:0] rise_v;

  pirq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (irq_raw),
    .d_out (sync_v)
  );

  pirq_regs #(.NUM_LINES(NUM_LINES), .HAS_EOI(HAS_EOI)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_o    (mask_v),
    .pol_o     (pol_v),
    .edge_o    (edge_v),
    .eoi_o     (eoi_v)
  );

  pirq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_v),
    .pol      (pol_v),
    .edge_sel (edge_v),
    .mask     (mask_v),
    .eoi      (eoi_v),
    .irq_out  (irq_out),
    .latch_o  (latch_v),
    .rise_o   (rise_v)
  );
endmodule

// File: rtl/pirq_checker.sv
`timescale 1ns/1ps
module pirq_checker #(
  parameter int NUM_LINES = 64,
  parameter bit HAS_EOI   = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic [7:0]           bus_addr,
  input logic [15:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_LINES-1:0] mask_v,
  input logic [NUM_LINES-1:0] latch_v,
  input logic [NUM_LINES-1:0] eoi_v,
  input logic [NUM_LINES-1:0] rise_v
);
  localparam int NUM_WORDS = (NUM_LINES + 15) / 16;

  logic unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[7:6] != 2'b00)
                  || (int'(bus_addr[3:2]) >= NUM_WORDS);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0));

  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irq_out & $past(mask_v)) == '0));

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(latch_v) & ~$past(eoi_v) & ~latch_v) == '0));

  p_eoi_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[5:4] == 2'b10) |=> (bus_rdata == 16'h0000));

  p_edge_beats_eoi_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(rise_v) & ~latch_v) == '0));

  p_no_eoi_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (!HAS_EOI && !$past(rst)) |-> (($past(latch_v) & ~latch_v) == '0));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == 16'h0000));
endmodule

bind pirq_frontend pirq_checker #(.NUM_LINES(NUM_LINES), .HAS_EOI(HAS_EOI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .mask_v    (mask_v),
  .latch_v   (latch_v),
  .eoi_v     (eoi_v),
  .rise_v    (rise_v)
);

// File: tb/pirq_frontend_test.sv
`timescale 1ns/1ps
module pirq_frontend_test;
  localparam int NL = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_raw = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   rdata_a, rdata_b;
  logic [NL-1:0] out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pirq_frontend #(.NUM_LINES(NL), .HAS_EOI(1'b1)) uut (
    .clk(clk), .rst(rst), .irq_raw(irq_raw), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_out(out_a)
  );

  pirq_frontend #(.NUM_LINES(NL), .HAS_EOI(1'b0)) uut_noeoi (
    .clk(clk), .rst(rst), .irq_raw(irq_raw), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_out(out_b)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata_a;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 outputs", 64'(out_a), 64'h0);
    bus_read(8'h00, d); check("R1 mask word0", 64'(d), 64'hFFFF);
    bus_read(8'h08, d); check("R1/R10 mask word2 unused bits", 64'(d), 64'h00FF);
    bus_read(8'h10, d); check("R1 polarity word0", 64'(d), 64'h0);
    bus_read(8'h34, d); check("R1 edge word1", 64'(d), 64'h0);
  endtask

  task automatic t_level();
    bus_write(8'h00, 16'hFFF7);        // unmask line 3 (R2: word0 bit3)
    @(negedge clk);
    irq_raw[3] = 1'b1;
    irq_raw[5] = 1'b1;
    wait_cyc(2);
    check("R4 not before third edge", 64'(out_a[3]), 64'h0);
    wait_cyc(1);
    check("R4 level passes on third edge", 64'(out_a[3]), 64'h1);
    check("R3 masked line stays low", 64'(out_a[5]), 64'h0);
    irq_raw[3] = 1'b0;
    irq_raw[5] = 1'b0;
    wait_cyc(4);
    check("R4 level follows input low", 64'(out_a[3]), 64'h0);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    bus_write(8'h14, 16'h0002);        // line 17: word1 bit1 inverted
    bus_write(8'h04, 16'hFFFD);
    wait_cyc(4);
    check("R5 low input active when inverted", 64'(out_a[17]), 64'h1);
    irq_raw[17] = 1'b1;
    wait_cyc(4);
    check("R5 high input idle when inverted", 64'(out_a[17]), 64'h0);
    bus_read(8'h14, d); check("R10 polarity readback", 64'(d), 64'h0002);
    bus_read(8'h04, d); check("R2/R10 mask word1 readback", 64'(d), 64'hFFFD);
  endtask

  task automatic pulse33();
    @(negedge clk);
    irq_raw[33] = 1'b1;
    wait_cyc(2);
    irq_raw[33] = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_edge();
    logic [15:0] d;
    bus_write(8'h38, 16'h0002);        // line 33 edge type
    bus_write(8'h08, 16'hFFFD);
    bus_read(8'h08, d); check("R10 unused mask bits not writable", 64'(d), 64'h00FD);
    pulse33();
    check("R6 edge latched after input idle", 64'(out_a[33]), 64'h1);
    check("R6 edge latched (no-eoi build)", 64'(out_b[33]), 64'h1);
  endtask

  task automatic t_mask_keeps_latch();
    bus_write(8'h08, 16'hFFFF);
    wait_cyc(2);
    check("R11 masked latch hidden", 64'(out_a[33]), 64'h0);
    bus_write(8'h08, 16'hFFFD);
    wait_cyc(2);
    check("R11 unmask shows kept latch", 64'(out_a[33]), 64'h1);
  endtask

  task automatic t_eoi();
    logic [15:0] d;
    bus_write(8'h28, 16'h0001);        // completes line 32 only
    wait_cyc(2);
    check("R7 zero eoi bit leaves latch", 64'(out_a[33]), 64'h1);
    bus_write(8'h28, 16'h0002);
    wait_cyc(2);
    check("R7 eoi clears latch", 64'(out_a[33]), 64'h0);
    check("R9 no-eoi build keeps latch", 64'(out_b[33]), 64'h1);
    bus_read(8'h28, d); check("R7 eoi bank reads zero", 64'(d), 64'h0);
  endtask

  task automatic t_eoi_race();
    pulse33();
    check("R8 setup latched", 64'(out_a[33]), 64'h1);
    @(negedge clk);
    irq_raw[33] = 1'b1;                // rise seen between 2nd and 3rd edge
    wait_cyc(2);
    bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_wr = 1'b0;
    wait_cyc(2);
    check("R8 edge with eoi keeps latch", 64'(out_a[33]), 64'h1);
    bus_write(8'h28, 16'h0002);
    wait_cyc(2);
    check("R8 later eoi without edge clears", 64'(out_a[33]), 64'h0);
    irq_raw[33] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    bus_write(8'h3C, 16'hFFFF);
    bus_read(8'h3C, d); check("R10 unmapped word reads zero", 64'(d), 64'h0);
    bus_write(8'h01, 16'h0000);
    bus_write(8'h40, 16'h0000);
    bus_read(8'h00, d); check("R10 misaligned/out-of-range writes ignored", 64'(d), 64'hFFF7);
    bus_read(8'h02, d); check("R10 misaligned read zero", 64'(d), 64'h0);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_level();
    t_polarity();
    t_edge();
    t_mask_keeps_latch();
    t_eoi();
    t_eoi_race();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule